// File: doc/BRIEF.md
# Per-Pin Configurable GPIO Port

This block is a small general-purpose I/O unit with two ports behind a four-register bus: a 16-pin port A and a 4-pin port B. Software sets each pin's direction through a 2-bit mode field in the port's control register. The port's data register sets the levels driven on output pins and returns the merged state of the port when read. The 20 pin drive values and 20 output enables leave the block as registered vectors. Port A is in bits 15:0 and port B in bits 19:16.

A mode code of 2 makes a pin an input. Codes 1 and 3 make it an output. Code 0 parks the pin: it is neither driven nor sampled. Every control write rebuilds both masks of that port from scratch. It also pushes the last value stored in the data register through the new output mask. A pin that becomes an output therefore drives the stored level at once, without another data write.

A register write lands on the clock edge that samples the write strobe. A read is a combinational view of the current state and the live pin inputs.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous reset, all control registers, data registers, masks and output latches are zero. `pin_oe` and `pin_out` are all zero, and every register reads back zero.
- R2: The control field of pin i is at control register bits [2i+1:2i]. Code 2 selects input. Codes 1 and 3 select output and set that pin's `pin_oe` bit. Code 0 selects neither.
- R3: A write to a data register sets that port's output latch to the written value ANDed with the output mask. `pin_out` never has a bit set where `pin_oe` is clear.
- R4: A data register read returns, in its low bits, the port's pin inputs ANDed with the input mask, ORed with the output latch. All higher read bits are zero.
- R5: A pin in mode 0 has its output enable low and reads back 0, whatever its pin input and whatever is written to the data register.
- R6: A control register write reloads the output latch with the stored data register value ANDed with the new output mask.
- R7: A control register write replaces both masks of its port completely. No pin keeps the direction it had before.
- R8: Port B has 4 pins. Its enables and drive values are at `pin_oe[19:16]` and `pin_out[19:16]`. Port A writes leave port B's state unchanged, and port B writes leave port A's state unchanged.
- R9: The register addresses are: 0 for port A control, 1 for port A data, 2 for port B control and 3 for port B data. A control register read returns the last value written, truncated to two bits per pin of that port.
- R10: A write takes effect on the rising clock edge where `wr_en` is high. Outputs keep their old values before that edge. While `wr_en` is low, no register changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register select |
| wr_data | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_data | output | 32 | Combinational read data for `addr` |
| pin_in | input | 20 | Pin input levels, port B in [19:16] |
| pin_out | output | 20 | Registered pin drive values |
| pin_oe | output | 20 | Registered pin output enables |

## Verification
A repeating nibble of the four mode codes puts every code on every pin position. This separates code 2 from codes 1 and 3, and both from code 0, and it would expose an off-by-one in the field layout. Reads are taken with all-ones, all-zeros and alternating pin inputs. These patterns distinguish input-masked bits from latched output bits and from parked pins. Control rewrites after a stored all-ones data value show whether the latch is re-masked or left stale. Writes to one port, followed by checks of the other port, show that the two ports do not interfere. A write strobe held up around a clock edge shows that state changes on that edge and not earlier.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL_A = 2'd0,
    SEL_DATA_A = 2'd1,
    SEL_CTRL_B = 2'd2,
    SEL_DATA_B = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    MODE_PARK    = 2'd0,
    MODE_DRIVE   = 2'd1,
    MODE_SAMPLE  = 2'd2,
    MODE_DRIVE_X = 2'd3
  } pin_mode_e;

endpackage

// File: rtl/gpio_mode_decode.sv
module gpio_mode_decode #(
  parameter int PINS = 16
) (
  input  logic [2*PINS-1:0] mode_field,
  output logic [PINS-1:0]   in_mask,
  output logic [PINS-1:0]   out_mask
);
  import gpio_cfg_pkg::*;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    pin_mode_e code;
    assign code        = pin_mode_e'(mode_field[2*i +: 2]);
    assign in_mask[i]  = (code == MODE_SAMPLE);
    assign out_mask[i] = (code == MODE_DRIVE) || (code == MODE_DRIVE_X);
  end

endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int PINS  = 16,
  parameter int BUS_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic              data_we,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [PINS-1:0]   pins_i,
  output logic [2*PINS-1:0] ctrl_q,
  output logic [PINS-1:0]   latch_q,
  output logic [PINS-1:0]   oe_q,
  output logic [PINS-1:0]   rd_val
);
  localparam int CTRL_W = 2 * PINS;

  logic [PINS-1:0] data_q;
  logic [PINS-1:0] in_mask_q;
  logic [PINS-1:0] dec_in;
  logic [PINS-1:0] dec_out;

  gpio_mode_decode #(.PINS(PINS)) u_dec (
    .mode_field (wdata[CTRL_W-1:0]),
    .in_mask    (dec_in),
    .out_mask   (dec_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      data_q    <= '0;
      in_mask_q <= '0;
      oe_q      <= '0;
      latch_q   <= '0;
    end else if (ctrl_we) begin
      ctrl_q    <= wdata[CTRL_W-1:0];
      in_mask_q <= dec_in;
      oe_q      <= dec_out;
      latch_q   <= data_q & dec_out;
    end else if (data_we) begin
      data_q    <= wdata[PINS-1:0];
      latch_q   <= wdata[PINS-1:0] & oe_q;
    end
  end

  assign rd_val = (pins_i & in_mask_q) | latch_q;

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux #(
  parameter int A_PINS = 16,
  parameter int B_PINS = 4,
  parameter int BUS_W  = 32
) (
  input  gpio_cfg_pkg::reg_sel_e sel,
  input  logic [2*A_PINS-1:0]    ctrl_a,
  input  logic [A_PINS-1:0]      data_a,
  input  logic [2*B_PINS-1:0]    ctrl_b,
  input  logic [B_PINS-1:0]      data_b,
  output logic [BUS_W-1:0]       rd
);
  import gpio_cfg_pkg::*;

  always_comb begin
    rd = '0;
    unique case (sel)
      SEL_CTRL_A: rd[2*A_PINS-1:0] = ctrl_a;
      SEL_DATA_A: rd[A_PINS-1:0]   = data_a;
      SEL_CTRL_B: rd[2*B_PINS-1:0] = ctrl_b;
      SEL_DATA_B: rd[B_PINS-1:0]   = data_b;
      default:    rd = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int A_PINS = 16,
  parameter int B_PINS = 4,
  parameter int BUS_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               addr,
  input  logic [BUS_W-1:0]         wr_data,
  input  logic                     wr_en,
  output logic [BUS_W-1:0]         rd_data,
  input  logic [A_PINS+B_PINS-1:0] pin_in,
  output logic [A_PINS+B_PINS-1:0] pin_out,
  output logic [A_PINS+B_PINS-1:0] pin_oe
);
  import gpio_cfg_pkg::*;

  localparam int TOTAL = A_PINS + B_PINS;

  reg_sel_e sel;
  assign sel = reg_sel_e'(addr);

  logic [2*A_PINS-1:0] ctrl_a;
  logic [2*B_PINS-1:0] ctrl_b;
  logic [A_PINS-1:0]   latch_a, oe_a, rd_a;
  logic [B_PINS-1:0]   latch_b, oe_b, rd_b;

  gpio_port_bank #(.PINS(A_PINS), .BUS_W(BUS_W)) u_bank_a (
    .clk     (clk),
    .rst     (rst),
    .ctrl_we (wr_en && sel == SEL_CTRL_A),
    .data_we (wr_en && sel == SEL_DATA_A),
    .wdata   (wr_data),
    .pins_i  (pin_in[A_PINS-1:0]),
    .ctrl_q  (ctrl_a),
    .latch_q (latch_a),
    .oe_q    (oe_a),
    .rd_val  (rd_a)
  );

  gpio_port_bank #(.PINS(B_PINS), .BUS_W(BUS_W)) u_bank_b (
    .clk     (clk),
    .rst     (rst),
    .ctrl_we (wr_en && sel == SEL_CTRL_B),
    .data_we (wr_en && sel == SEL_DATA_B),
    .wdata   (wr_data),
    .pins_i  (pin_in[TOTAL-1:A_PINS]),
    .ctrl_q  (ctrl_b),
    .latch_q (latch_b),
    .oe_q    (oe_b),
    .rd_val  (rd_b)
  );

  gpio_read_mux #(.A_PINS(A_PINS), .B_PINS(B_PINS), .BUS_W(BUS_W)) u_rd (
    .sel    (sel),
    .ctrl_a (ctrl_a),
    .data_a (rd_a),
    .ctrl_b (ctrl_b),
    .data_b (rd_b),
    .rd     (rd_data)
  );

  assign pin_out = {latch_b, latch_a};
  assign pin_oe  = {oe_b, oe_a};

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int A_PINS = 16,
  parameter int B_PINS = 4,
  parameter int BUS_W  = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic [1:0]               addr,
  input logic [BUS_W-1:0]         wr_data,
  input logic                     wr_en,
  input logic [BUS_W-1:0]         rd_data,
  input logic [A_PINS+B_PINS-1:0] pin_in,
  input logic [A_PINS+B_PINS-1:0] pin_out,
  input logic [A_PINS+B_PINS-1:0] pin_oe
);
  localparam int TOTAL = A_PINS + B_PINS;

  logic rst_q;
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q === 1'b1) begin
      p_reset_clear_r1: assert (pin_oe == '0 && pin_out == '0)
        else $error("outputs not cleared after reset");
    end
  end

  p_out_within_oe_r3: assert property (@(posedge clk) disable iff (rst)
    (pin_out & ~pin_oe) == '0);

  p_data_write_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd1) |=>
      pin_out[A_PINS-1:0] == ($past(wr_data[A_PINS-1:0]) & pin_oe[A_PINS-1:0]));

  p_undriven_low_r5: assert property (@(posedge clk) disable iff (rst)
    (addr == 2'd1) |->
      ((rd_data[A_PINS-1:0] & ~pin_oe[A_PINS-1:0] & ~pin_in[A_PINS-1:0]) == '0));

  p_a_write_keeps_b_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr[1]) |=>
      ($stable(pin_out[TOTAL-1:A_PINS]) && $stable(pin_oe[TOTAL-1:A_PINS])));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

bind gpio_port gpio_port_chk #(.A_PINS(A_PINS), .B_PINS(B_PINS), .BUS_W(BUS_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (addr),
  .wr_data (wr_data),
  .wr_en   (wr_en),
  .rd_data (rd_data),
  .pin_in  (pin_in),
  .pin_out (pin_out),
  .pin_oe  (pin_oe)
);

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic        wr_en = 1'b0;
  logic [31:0] rd_data;
  logic [19:0] pin_in = '0;
  logic [19:0] pin_out;
  logic [19:0] pin_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  gpio_port dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // reference state kept from the requirements
  logic [31:0] m_ctrl_a = '0, m_ctrl_b = '0;
  logic [15:0] m_data_a = '0;
  logic [3:0]  m_data_b = '0;

  function automatic logic [15:0] f_mask(input logic [31:0] c, input int pins, input bit want_in);
    logic [15:0] m = '0;
    for (int i = 0; i < pins; i++) begin
      logic [1:0] code = c[2*i +: 2];
      m[i] = want_in ? (code == 2'd2) : (code == 2'd1 || code == 2'd3);
    end
    return m;
  endfunction

  function automatic logic [19:0] f_oe();
    return {f_mask(m_ctrl_b, 4, 1'b0)[3:0], f_mask(m_ctrl_a, 16, 1'b0)};
  endfunction

  function automatic logic [19:0] f_out();
    return f_oe() & {m_data_b, m_data_a};
  endfunction

  function automatic logic [31:0] f_read(input logic [1:0] a);
    logic [19:0] o = f_out();
    case (a)
      2'd0: return m_ctrl_a;
      2'd1: return {16'h0, (pin_in[15:0] & f_mask(m_ctrl_a, 16, 1'b1)) | o[15:0]};
      2'd2: return {24'h0, m_ctrl_b[7:0]};
      default: return {28'h0, (pin_in[19:16] & f_mask(m_ctrl_b, 4, 1'b1)[3:0]) | o[19:16]};
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h, expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      2'd0: m_ctrl_a = d;
      2'd1: m_data_a = d[15:0];
      2'd2: m_ctrl_b = {24'h0, d[7:0]};
      default: m_data_b = d[3:0];
    endcase
  endtask

  task automatic chk_pins(input string req);
    check(req, {12'h0, pin_oe}, {12'h0, f_oe()});
    check(req, {12'h0, pin_out}, {12'h0, f_out()});
  endtask

  task automatic chk_read(input string req, input logic [1:0] a);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rd_data, f_read(a));
  endtask

  task automatic t_reset_r1();
    pin_in = '1;
    check("R1 oe", {12'h0, pin_oe}, 32'h0);
    check("R1 out", {12'h0, pin_out}, 32'h0);
    for (int a = 0; a < 4; a++) begin
      @(negedge clk); addr = a[1:0]; #1;
      check("R1 read", rd_data, 32'h0);
    end
  endtask

  task automatic t_decode_r2();
    wr(2'd0, 32'hE4E4_E4E4); // pins cycle through codes 0,1,2,3
    check("R2 oe", {16'h0, pin_oe[15:0]}, 32'h0000_AAAA);
    pin_in = 20'h0FFFF;
    chk_read("R2 input mask", 2'd1);
    check("R2 read inputs", rd_data, 32'h0000_4444);
  endtask

  task automatic t_data_r3();
    wr(2'd1, 32'h0000_FFFF);
    check("R3 masked all ones", {16'h0, pin_out[15:0]}, 32'h0000_AAAA);
    wr(2'd1, 32'hFFFF_1234);
    chk_pins("R3 pattern");
  endtask

  task automatic t_merge_r4();
    logic [19:0] pats [3] = '{20'hFFFFF, 20'h00000, 20'hA5A5A};
    for (int k = 0; k < 3; k++) begin
      pin_in = pats[k];
      chk_read("R4 merge A", 2'd1);
    end
  endtask

  task automatic t_park_r5();
    wr(2'd1, 32'h0000_FFFF);
    pin_in = 20'hFFFFF;
    chk_read("R5 parked", 2'd1);
    check("R5 parked read bits", rd_data & 32'h1111, 32'h0);
    check("R5 parked oe", {16'h0, pin_oe[15:0]} & 32'h1111, 32'h0);
  endtask

  task automatic t_reapply_r6();
    wr(2'd0, 32'h5555_5555); // all output, no data write
    check("R6 reapplied", {16'h0, pin_out[15:0]}, 32'h0000_FFFF);
    chk_pins("R6 pins");
  endtask

  task automatic t_replace_r7();
    wr(2'd0, 32'hAAAA_AAAA); // all input
    check("R7 oe cleared", {16'h0, pin_oe[15:0]}, 32'h0);
    check("R7 out cleared", {16'h0, pin_out[15:0]}, 32'h0);
    pin_in = 20'h0C3A5;
    chk_read("R7 reads inputs", 2'd1);
    check("R7 read value", rd_data, 32'h0000_C3A5);
  endtask

  task automatic t_port_b_r8();
    logic [15:0] a_out = pin_out[15:0];
    logic [15:0] a_oe  = pin_oe[15:0];
    wr(2'd2, 32'h0000_00B1); // pin0=1 pin1=0 pin2=3 pin3=2
    check("R8 B oe", {28'h0, pin_oe[19:16]}, 32'h5);
    wr(2'd3, 32'hFFFF_FFFF);
    check("R8 B out", {28'h0, pin_out[19:16]}, 32'h5);
    check("R8 A out kept", {16'h0, pin_out[15:0]}, {16'h0, a_out});
    check("R8 A oe kept", {16'h0, pin_oe[15:0]}, {16'h0, a_oe});
    pin_in = 20'hF0000;
    chk_read("R8 B read", 2'd3);
    check("R8 B read value", rd_data, 32'hD);
    wr(2'd0, 32'h5555_5555);
    wr(2'd1, 32'h0000_0F0F);
    check("R8 B kept", {28'h0, pin_out[19:16]}, 32'h5);
    chk_pins("R8 pins");
  endtask

  task automatic t_readback_r9();
    wr(2'd0, 32'h1B2C_3D4E);
    chk_read("R9 ctrl A", 2'd0);
    check("R9 ctrl A value", rd_data, 32'h1B2C_3D4E);
    wr(2'd2, 32'hFFFF_FFFF);
    chk_read("R9 ctrl B", 2'd2);
    check("R9 ctrl B value", rd_data, 32'h0000_00FF);
  endtask

  task automatic t_timing_r10();
    wr(2'd0, 32'h0);
    @(negedge clk);
    addr = 2'd0; wr_data = 32'h5555_5555; wr_en = 1'b1;
    #1;
    check("R10 before edge", {16'h0, pin_oe[15:0]}, 32'h0);
    @(negedge clk);
    wr_en = 1'b0; m_ctrl_a = 32'h5555_5555;
    check("R10 after edge", {16'h0, pin_oe[15:0]}, 32'h0000_FFFF);
    for (int a = 0; a < 4; a++) begin
      @(negedge clk); addr = a[1:0]; wr_data = 32'h0;
    end
    @(negedge clk);
    chk_pins("R10 no strobe");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_r1();
    t_decode_r2();
    t_data_r3();
    t_merge_r4();
    t_park_r5();
    t_reapply_r6();
    t_replace_r7();
    t_port_b_r8();
    t_readback_r9();
    t_timing_r10();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule